// File: doc/BRIEF.md
# UART Transmitter with RS485 Turnaround

This block is the transmit half of a single serial channel. The host pushes bytes through a one-cycle write strobe into a 256-entry queue. A shift register takes them from the queue and sends them on a line that idles high. Each byte goes out as a frame of 10 bits. Bit timing comes from an oversampling tick: the system clock is divided by a programmable prescaler, and each bit lasts 16, 8 or 4 of those ticks.

The block reports two empty conditions: the queue is empty, and the whole path is empty. It also raises a maskable transmit interrupt. Normally the interrupt is raised when the queue level falls below a programmable threshold. When half-duplex line-driver control is switched on, the interrupt instead tracks the whole path going empty.

In half-duplex mode a direction output is raised before the first start bit. It stays high across back-to-back frames. It is released a programmable number of bit times (0 to 15) after the stop bit of the final byte. This holds the line driver on long enough for the last character to reach every station before the transceiver turns around. A byte written during that countdown keeps the driver on, and sending resumes.

Top module: `uart_tx_rs485`

## Requirements
- R1: Each byte is sent as one low start bit, then the 8 data bits least significant bit first, then one high stop bit. While nothing is being sent, txd is 1.
- R2: One bit lasts ratio*(cfg_div+1) clocks. The ratio is set by cfg_os_sel: 0 gives 16, 1 gives 8, 2 gives 4, and 3 gives 16.
- R3: The queue holds up to 256 bytes, and bytes leave in the order they were written. A write when fifo_level is 256 is dropped, even if a byte leaves in the same cycle. overflow is then 1 for exactly the one cycle after that write. An accepted write never raises overflow.
- R4: thr_empty is 1 exactly when fifo_level is 0.
- R5: tsr_empty is 1 only when the queue is empty and no frame is in progress. When it is 1, txd is 1.
- R6: When cfg_rs485_en is 0, tx_irq equals cfg_irq_en AND (fifo_level < cfg_trig).
- R7: When cfg_rs485_en is 1, tx_irq equals cfg_irq_en AND tsr_empty. The queue level then has no effect.
- R8: With cfg_rs485_en at 1, dir_out rises in the cycle after a write to an idle block. That is one clock before txd falls for the start bit.
- R9: Bytes queued while a frame is in progress follow with no idle gap between frames, and dir_out stays high throughout. With cfg_div at 0, three bytes written on consecutive cycles to an idle block keep dir_out high for 30*bit+1 clocks.
- R10: After the stop bit of the last byte, dir_out stays high for cfg_turn_dly bit times, then drops. With cfg_div at 0, a single byte keeps dir_out high for (10+cfg_turn_dly)*bit+1 clocks.
- R11: A write accepted during the turnaround countdown keeps dir_out high without a break, and the new byte is sent.
- R12: While cfg_rs485_en is 0, dir_out stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| cfg_div | input | 16 | Oversampling prescaler; a tick every cfg_div+1 clocks |
| cfg_os_sel | input | 2 | Ticks per bit: 0=16, 1=8, 2=4, 3=16 |
| cfg_trig | input | 9 | Queue level threshold for the interrupt in normal mode |
| cfg_irq_en | input | 1 | Transmit interrupt enable |
| cfg_rs485_en | input | 1 | Half-duplex direction control enable |
| cfg_turn_dly | input | 4 | Turnaround delay in bit times |
| txd | output | 1 | Serial output, idles high |
| dir_out | output | 1 | Line driver enable |
| thr_empty | output | 1 | Queue empty |
| tsr_empty | output | 1 | Queue and shift register both empty |
| tx_irq | output | 1 | Transmit interrupt |
| overflow | output | 1 | One-cycle pulse for a dropped write |
| fifo_level | output | 9 | Bytes in the queue |

## Verification
A host write can arrive while the turnaround countdown is running. The countdown and the shifter's reload then compete for the same cycle. The bench provokes this by writing a byte ten clocks into a 15-bit delay. It then judges the result from the length of one unbroken dir_out pulse and the byte the scoreboard receives. Another clash is a write meeting a full queue: a burst of 260 writes is sent against a slow bit clock. The bench then checks that exactly three overflow pulses appear and that the level holds at 256.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam logic [1:0] OSR_16 = 2'd0;
  localparam logic [1:0] OSR_8  = 2'd1;
  localparam logic [1:0] OSR_4  = 2'd2;

  // Oversampling ticks per bit for a given selector.
  function automatic logic [4:0] os_ratio(input logic [1:0] sel);
    case (sel)
      OSR_8:   return 5'd8;
      OSR_4:   return 5'd4;
      OSR_16:  return 5'd16;
      default: return 5'd16;
    endcase
  endfunction

  // Oversampling ticks in a turnaround delay of dly bit times.
  function automatic logic [8:0] turn_ticks(input logic [3:0] dly, input logic [1:0] sel);
    return {5'd0, dly} * {4'd0, os_ratio(sel)};
  endfunction
endpackage

// File: rtl/tx_baud_gen.sv
module tx_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             os_tick
);
  logic [DIV_W-1:0] cnt;

  assign os_tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (os_tick) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          overflow
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= push && full;
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = DW + 2,
  parameter int IW = $clog2(FW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic [1:0]    os_sel,
  input  logic          have_data,
  input  logic [DW-1:0] din,
  output logic          load,
  output logic          busy,
  output logic          stop_done,
  output logic          txd
);
  logic [FW-1:0] frame;
  logic [IW-1:0] bit_idx;
  logic [4:0]    phase;
  logic          bit_end, last_bit;

  assign last_bit  = (bit_idx == IW'(FW - 1));
  assign bit_end   = busy && os_tick && (phase >= os_ratio(os_sel) - 5'd1);
  assign stop_done = bit_end && last_bit;
  assign load      = have_data && (!busy || stop_done);
  assign txd       = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame   <= '1;
      bit_idx <= '0;
      phase   <= '0;
      busy    <= 1'b0;
    end else if (load) begin
      frame   <= {1'b1, din, 1'b0};
      bit_idx <= '0;
      phase   <= '0;
      busy    <= 1'b1;
    end else if (bit_end) begin
      phase <= '0;
      if (last_bit) begin
        busy <= 1'b0;
      end else begin
        frame   <= {1'b1, frame[FW-1:1]};
        bit_idx <= bit_idx + 1'b1;
      end
    end else if (busy && os_tick) begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/tx_dir_ctrl.sv
module tx_dir_ctrl
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       os_tick,
  input  logic [1:0] os_sel,
  input  logic [3:0] dly,
  input  logic       stop_done,
  input  logic       have_data,
  input  logic       busy,
  output logic       hold_active,
  output logic       hold_expire,
  output logic       dir_out
);
  logic [8:0] rem;
  logic       start_hold;

  assign start_hold  = en && stop_done && !have_data && (dly != 4'd0);
  assign hold_expire = hold_active && os_tick && !have_data && (rem <= 9'd1);
  assign dir_out     = en && (busy || have_data || hold_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_active <= 1'b0;
      rem         <= '0;
    end else if (!en) begin
      hold_active <= 1'b0;
    end else if (start_hold) begin
      hold_active <= 1'b1;
      rem         <= turn_ticks(dly, os_sel);
    end else if (hold_active && have_data) begin
      hold_active <= 1'b0;
    end else if (hold_expire) begin
      hold_active <= 1'b0;
    end else if (hold_active && os_tick) begin
      rem <= rem - 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_rs485.sv
module uart_tx_rs485
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int DIV_W = 16,
  parameter int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_os_sel,
  input  logic [LVL_W-1:0] cfg_trig,
  input  logic             cfg_irq_en,
  input  logic             cfg_rs485_en,
  input  logic [3:0]       cfg_turn_dly,
  output logic             txd,
  output logic             dir_out,
  output logic             thr_empty,
  output logic             tsr_empty,
  output logic             tx_irq,
  output logic             overflow,
  output logic [LVL_W-1:0] fifo_level
);
  // Named internal events, brought out for the checker.
  logic          os_tick;
  logic          load_evt;
  logic          busy;
  logic          stop_done;
  logic          hold_active;
  logic          hold_expire;
  logic          fifo_empty, fifo_full;
  logic [DW-1:0] fifo_dout;
  logic          irq_src;

  tx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .os_tick(os_tick)
  );

  tx_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(load_evt),
    .dout(fifo_dout), .level(fifo_level), .empty(fifo_empty), .full(fifo_full),
    .overflow(overflow)
  );

  tx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os_sel(cfg_os_sel),
    .have_data(!fifo_empty), .din(fifo_dout), .load(load_evt), .busy(busy),
    .stop_done(stop_done), .txd(txd)
  );

  tx_dir_ctrl u_dir (
    .clk(clk), .rst_n(rst_n), .en(cfg_rs485_en), .os_tick(os_tick),
    .os_sel(cfg_os_sel), .dly(cfg_turn_dly), .stop_done(stop_done),
    .have_data(!fifo_empty), .busy(busy), .hold_active(hold_active),
    .hold_expire(hold_expire), .dir_out(dir_out)
  );

  assign thr_empty = fifo_empty;
  assign tsr_empty = fifo_empty && !busy;

  // Interrupt source: level threshold normally, whole-path empty in half duplex.
  assign irq_src = cfg_rs485_en ? tsr_empty : (fifo_level < cfg_trig);
  assign tx_irq  = cfg_irq_en && irq_src;
endmodule

// File: rtl/uart_tx_rs485_chk.sv
module uart_tx_rs485_chk #(
  parameter int DEPTH = 256,
  parameter int LVL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [LVL_W-1:0] cfg_trig,
  input logic             cfg_irq_en,
  input logic             cfg_rs485_en,
  input logic             txd,
  input logic             dir_out,
  input logic             thr_empty,
  input logic             tsr_empty,
  input logic             tx_irq,
  input logic             overflow,
  input logic [LVL_W-1:0] fifo_level,
  input logic             hold_active,
  input logic             load_evt
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_level < LVL_W'(DEPTH)) |=> !overflow);

  a_r3_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_level == LVL_W'(DEPTH)) |=> overflow);

  a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && thr_empty) |=> !thr_empty || load_evt == 1'b0);

  a_r5_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    tsr_empty |-> txd);

  a_r5_queue_first: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_empty |-> !tsr_empty);

  a_r6_empty_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rs485_en && cfg_irq_en && thr_empty && cfg_trig != '0) |-> tx_irq);

  a_r7_busy_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rs485_en && !tsr_empty) |-> !tx_irq);

  a_r8_dir_leads_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rs485_en && $past(cfg_rs485_en) && $fell(txd)) |-> $past(dir_out));

  a_r10_dir_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rs485_en && !tsr_empty) |-> dir_out);

  a_r11_hold_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rs485_en && hold_active) |-> dir_out);

  a_r12_no_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rs485_en |-> !dir_out);
endmodule

bind uart_tx_rs485 uart_tx_rs485_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_trig(cfg_trig),
  .cfg_irq_en(cfg_irq_en), .cfg_rs485_en(cfg_rs485_en), .txd(txd),
  .dir_out(dir_out), .thr_empty(thr_empty), .tsr_empty(tsr_empty),
  .tx_irq(tx_irq), .overflow(overflow), .fifo_level(fifo_level),
  .hold_active(hold_active), .load_evt(load_evt)
);

// File: tb/uart_tx_rs485_tb.sv
module uart_tx_rs485_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [15:0] cfg_div = 16'd0;
  logic [1:0] cfg_os_sel = 2'd2;
  logic [8:0] cfg_trig = 9'd0;
  logic       cfg_irq_en = 1'b0;
  logic       cfg_rs485_en = 1'b0;
  logic [3:0] cfg_turn_dly = 4'd0;
  logic       txd, dir_out, thr_empty, tsr_empty, tx_irq, overflow;
  logic [8:0] fifo_level;

  int n_cmp = 0;
  int n_bad = 0;
  int bitclk = 4;
  bit sb_on = 1'b1;
  bit done = 1'b0;
  int ovf_cnt = 0;
  logic [7:0] sbq[$];

  always #10 clk = ~clk;

  uart_tx_rs485 u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_div(cfg_div), .cfg_os_sel(cfg_os_sel), .cfg_trig(cfg_trig),
    .cfg_irq_en(cfg_irq_en), .cfg_rs485_en(cfg_rs485_en),
    .cfg_turn_dly(cfg_turn_dly), .txd(txd), .dir_out(dir_out),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty), .tx_irq(tx_irq),
    .overflow(overflow), .fifo_level(fifo_level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Bit time in clocks from the rule stated in R2.
  function automatic int bit_clocks(input logic [1:0] sel, input logic [15:0] div);
    int r;
    r = (sel == 2'd1) ? 8 : (sel == 2'd2) ? 4 : 16;
    return r * (int'(div) + 1);
  endfunction

  task automatic set_cfg(input logic [1:0] sel, input logic [15:0] div,
                         input bit rs, input logic [3:0] dly);
    @(negedge clk);
    cfg_os_sel = sel; cfg_div = div; cfg_rs485_en = rs; cfg_turn_dly = dly;
    bitclk = bit_clocks(sel, div);
  endtask

  // Driver: writes n bytes on consecutive cycles and queues expected bytes.
  task automatic burst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = base + 8'(i * 37);
      if (sb_on) sbq.push_back(wr_data);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure_dir(output int n);
    n = 0;
    do @(negedge clk); while (!dir_out);
    while (dir_out) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tsr_empty && !dir_out && sbq.size() == 0));
    repeat (2 * bitclk) @(negedge clk);
  endtask

  // Monitor: decodes frames by mid-bit sampling and compares with the queue (R1, R2, R3).
  initial begin
    logic [7:0] got;
    logic       stp;
    forever begin
      do @(negedge clk); while (txd !== 1'b0);
      repeat (bitclk / 2) @(negedge clk);
      if (sb_on) check(txd == 1'b0, "R1 start bit", int'(txd), 0);
      for (int b = 0; b < 8; b++) begin
        repeat (bitclk) @(negedge clk);
        got[b] = txd;
      end
      repeat (bitclk) @(negedge clk);
      stp = txd;
      if (sb_on) begin
        check(stp == 1'b1, "R1 stop bit", int'(stp), 1);
        if (sbq.size() == 0) begin
          check(1'b0, "R3 unexpected byte", int'(got), -1);
        end else begin
          logic [7:0] exp;
          exp = sbq.pop_front();
          check(got == exp, "R1/R3 data byte", int'(got), int'(exp));
        end
      end
    end
  end

  always @(negedge clk) if (overflow) ovf_cnt++;

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check(txd == 1'b1, "R1 idle txd", int'(txd), 1);
    check(thr_empty == 1'b1, "R4 reset empty", int'(thr_empty), 1);
    check(tsr_empty == 1'b1, "R5 reset empty", int'(tsr_empty), 1);
    check(dir_out == 1'b0, "R12 reset dir", int'(dir_out), 0);
    check(fifo_level == 9'd0, "R4 reset level", int'(fifo_level), 0);
    check(tx_irq == 1'b0, "R6 reset irq", int'(tx_irq), 0);

    // R12: direction stays low in normal mode
    set_cfg(2'd2, 16'd0, 1'b0, 4'd5);
    cnt = 0;
    fork
      burst(1, 8'hA5);
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (dir_out) cnt++;
      end
    join
    check(cnt == 0, "R12 dir off", cnt, 0);
    wait_idle();

    // R9: back-to-back frames, no gap, 30*bit+1
    set_cfg(2'd2, 16'd0, 1'b1, 4'd0);
    fork
      measure_dir(n);
      burst(3, 8'h3C);
    join
    check(n == 30 * 4 + 1, "R9 back-to-back dir", n, 121);
    wait_idle();

    // R10: turnaround delay in bit times
    set_cfg(2'd2, 16'd0, 1'b1, 4'd3);
    fork measure_dir(n); burst(1, 8'h81); join
    check(n == 13 * 4 + 1, "R10 delay 3 at 4x", n, 53);
    wait_idle();
    set_cfg(2'd1, 16'd0, 1'b1, 4'd15);
    fork measure_dir(n); burst(1, 8'h5A); join
    check(n == 25 * 8 + 1, "R10 delay 15 at 8x", n, 201);
    wait_idle();
    set_cfg(2'd0, 16'd0, 1'b1, 4'd0);
    fork measure_dir(n); burst(1, 8'hC3); join
    check(n == 10 * 16 + 1, "R10 delay 0 at 16x", n, 161);
    wait_idle();

    // R2: prescaled bit timing, checked by the monitor
    set_cfg(2'd1, 16'd1, 1'b0, 4'd0);
    burst(4, 8'h17);
    wait_idle();
    set_cfg(2'd3, 16'd2, 1'b0, 4'd0);
    burst(2, 8'hE4);
    wait_idle();

    // R8: direction leads start bit by one clock
    set_cfg(2'd2, 16'd0, 1'b1, 4'd0);
    burst(1, 8'h96);
    check(dir_out == 1'b1, "R8 dir up", int'(dir_out), 1);
    check(txd == 1'b1, "R8 start not yet", int'(txd), 1);
    @(negedge clk);
    check(txd == 1'b0, "R8 start follows", int'(txd), 0);
    wait_idle();

    // R11: write during turnaround countdown
    set_cfg(2'd2, 16'd0, 1'b1, 4'd15);
    fork
      measure_dir(n);
      begin
        burst(1, 8'h44);
        do @(negedge clk); while (!tsr_empty);
        repeat (10) @(negedge clk);
        burst(1, 8'h99);
      end
    join
    check(n >= 142 && n <= 165, "R11 dir unbroken", n, 153);
    wait_idle();

    // R6: threshold interrupt in normal mode
    set_cfg(2'd2, 16'd0, 1'b0, 4'd0);
    cfg_trig = 9'd4; cfg_irq_en = 1'b1;
    @(negedge clk);
    check(tx_irq == 1'b1, "R6 empty below trig", int'(tx_irq), 1);
    burst(6, 8'h20);
    check(fifo_level == 9'd5, "R6 level after burst", int'(fifo_level), 5);
    check(tx_irq == 1'b0, "R6 above trig", int'(tx_irq), 0);
    do @(negedge clk); while (fifo_level != 9'd3);
    check(tx_irq == 1'b1, "R6 fell below trig", int'(tx_irq), 1);
    cfg_irq_en = 1'b0;
    @(negedge clk);
    check(tx_irq == 1'b0, "R6 masked", int'(tx_irq), 0);
    cfg_irq_en = 1'b1;
    wait_idle();

    // R7: half-duplex interrupt tracks whole-path empty
    set_cfg(2'd2, 16'd0, 1'b1, 4'd0);
    burst(1, 8'h6D);
    check(tx_irq == 1'b0, "R7 queued", int'(tx_irq), 0);
    repeat (3) @(negedge clk);
    check(thr_empty == 1'b1, "R4 queue drained", int'(thr_empty), 1);
    check(tx_irq == 1'b0, "R7 shifting no irq", int'(tx_irq), 0);
    do @(negedge clk); while (!tsr_empty);
    check(tx_irq == 1'b1, "R7 path empty irq", int'(tx_irq), 1);
    wait_idle();
    check(sbq.size() == 0, "R3 all bytes sent", sbq.size(), 0);

    // R3: overflow against a slow bit clock
    cfg_irq_en = 1'b0;
    set_cfg(2'd0, 16'd100, 1'b0, 4'd0);
    sb_on = 1'b0;
    ovf_cnt = 0;
    burst(260, 8'h01);
    @(negedge clk);
    check(fifo_level == 9'd256, "R3 full level", int'(fifo_level), 256);
    check(ovf_cnt == 3, "R3 dropped writes", ovf_cnt, 3);
    check(thr_empty == 1'b0, "R4 full not empty", int'(thr_empty), 0);
    finish_run();
  end
endmodule